// File: doc/BRIEF.md
# Character LCD Host Bus Interface

This block is the host side of a character LCD controller. A processor talks to it over a small parallel bus: an enable strobe, a register-select line, a read/write line and an 8-bit data bus. Each transfer is taken when the enable strobe falls. The bus can carry a whole byte per strobe, or it can carry a byte as two 4-bit halves on the upper four data pins.

The block decodes a handful of instructions. One sets the display-data RAM address and one sets the character-generator RAM address. Others change the data length and the address step direction. Beyond instructions, it handles status reads, data writes and data reads. Both RAMs sit inside the block and share one 7-bit address counter. A data register holds the byte that the next data read will return, and it is refilled ahead of time.

After every accepted instruction or data write, a busy flag stays high for a fixed number of clock cycles. The host polls this flag with a status read before it sends the next command.

Top module: `lcd_host_if`

## Requirements
- R1: With the data length set to 8 bits (bit4 of function set = 1, the reset value), one enable strobe carries a full byte on `db_in[7:0]`. For reads, the byte is presented on `db_out[7:0]`.
- R2: With the data length set to 4 bits, a byte takes two strobes, high half first, each on `db_in[7:4]`. `db_in[3:0]` is ignored. Reads return the high half and then the low half on `db_out[7:4]`, with `db_out[3:0]` = 0.
- R3: Instruction `01aaaaaa` (rs=0, rw=0) loads address counter bits 5:0 and keeps bit 6. It selects the character RAM for later data accesses.
- R4: Instruction `1aaaaaaa` loads all 7 address counter bits and selects the display RAM.
- R5: A status read (rs=0, rw=1) returns `{busy, counter[6:0]}` and is served even while busy. It changes neither the counter nor the data register.
- R6: A data write (rs=1, rw=0) stores into the selected RAM at the counter. The counter then steps by one modulo 128: up when entry-mode instruction `000001ds` has d=1 (the reset value), down when d=0. Only bits 4:0 are kept in the character RAM, and bits 7:5 read back as 0.
- R7: Counting up through character RAM writes carries from address 63 into counter bit 6.
- R8: A data read (rs=1, rw=1) returns the data register. The counter then steps, and the data register is refilled from the RAM location at the new counter value.
- R9: Only the two address-set instructions and data reads change the data register. Data writes leave it unchanged.
- R10: An accepted instruction, write or read holds busy high for exactly BUSY_CYC clock cycles. A transfer other than a status read that completes while busy is dropped. In 4-bit mode every strobe still advances the half-byte phase.
- R11: Instruction `001lxxxx` sets the data length from bit l (1 = 8-bit) and returns the half-byte phase to "high half".
- R12: After reset the counter is 0, the display RAM is selected, stepping is upward, the width is 8 bits, busy is low and `db_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable strobe; transfer taken on its falling edge |
| rs | input | 1 | Register select: 0 instruction/status, 1 data |
| rw | input | 1 | 1 read, 0 write |
| db_in | input | 8 | Data bus from host |
| db_out | output | 8 | Data bus to host, valid one clock after en rises on a read |
| db_oe | output | 1 | Bus drive enable (en high with rw high, registered) |
| busy | output | 1 | Internal operation in progress |

## Verification
The strobe fall is seen one clock late, and the transfer's effect follows one clock after that. Busy therefore rises two clocks after en falls, and a refilled data register is valid two clocks after that. Read data on `db_out` is registered one clock after `en` rises, so the bench holds `en` high for two clocks and samples at the falling clock edge just before dropping it. After each operation the bench idles for more than BUSY_CYC plus the pipeline delay. The back-to-back cases are the exception: there the second strobe is timed to land inside the busy window.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  typedef enum logic {TGT_DD = 1'b0, TGT_CG = 1'b1} ram_tgt_e;
  // encoded as {rs, rw}
  typedef enum logic [1:0] {
    OP_INSTR = 2'b00,
    OP_STAT  = 2'b01,
    OP_WR    = 2'b10,
    OP_RD    = 2'b11
  } bus_op_e;
  typedef struct packed {
    bus_op_e    op;
    logic [7:0] data;
  } xfer_t;
endpackage

// File: rtl/lcd_bus_rx.sv
module lcd_bus_rx import lcd_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          rs,
  input  logic          rw,
  input  logic [DW-1:0] db,
  input  logic          dl,
  output logic          phase,
  output logic          done,
  output xfer_t         xfer
);
  localparam int HW = DW / 2;

  logic          e_d;
  logic          dl_d;
  logic [HW-1:0] hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      e_d   <= 1'b0;
      dl_d  <= 1'b1;
      phase <= 1'b0;
      done  <= 1'b0;
      hi    <= '0;
      xfer  <= '0;
    end else begin
      e_d  <= en;
      dl_d <= dl;
      done <= 1'b0;
      if (dl != dl_d) begin
        phase <= 1'b0;
      end else if (e_d && !en) begin
        if (dl) begin
          done <= 1'b1;
          xfer <= '{op: bus_op_e'({rs, rw}), data: db};
        end else if (!phase) begin
          phase <= 1'b1;
          hi    <= db[DW-1:HW];
        end else begin
          phase <= 1'b0;
          done  <= 1'b1;
          xfer  <= '{op: bus_op_e'({rs, rw}), data: {hi, db[DW-1:HW]}};
        end
      end
    end
  end
endmodule

// File: rtl/lcd_sp_ram.sv
module lcd_sp_ram #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if import lcd_pkg::*; #(
  parameter int AW       = 7,
  parameter int CG_AW    = 6,
  parameter int CG_DW    = 5,
  parameter int DW       = 8,
  parameter int BUSY_CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          rs,
  input  logic          rw,
  input  logic [DW-1:0] db_in,
  output logic [DW-1:0] db_out,
  output logic          db_oe,
  output logic          busy
);
  localparam int HW = DW / 2;
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic          rx_done;
  logic          rx_phase;
  xfer_t         rx_xfer;
  logic [AW-1:0] ac;
  ram_tgt_e      tgt;
  logic          inc;
  logic          dl;
  logic [DW-1:0] dr;
  logic [CW-1:0] bcnt;
  logic          rl1, rl2;
  logic          busy_w;
  logic          accept;
  logic [AW-1:0] ac_step;
  logic          dd_we, cg_we;
  logic [DW-1:0]    dd_q;
  logic [CG_DW-1:0] cg_q;
  logic [DW-1:0] rd_byte;

  lcd_bus_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .en(en), .rs(rs), .rw(rw), .db(db_in),
    .dl(dl), .phase(rx_phase), .done(rx_done), .xfer(rx_xfer)
  );

  assign busy_w  = (bcnt != '0);
  assign busy    = busy_w;
  assign accept  = rx_done && !busy_w && (rx_xfer.op != OP_STAT);
  assign ac_step = inc ? ac + 1'b1 : ac - 1'b1;
  assign dd_we   = accept && (rx_xfer.op == OP_WR) && (tgt == TGT_DD);
  assign cg_we   = accept && (rx_xfer.op == OP_WR) && (tgt == TGT_CG);

  lcd_sp_ram #(.AW(AW), .DW(DW)) u_ddram (
    .clk(clk), .we(dd_we), .addr(ac), .wdata(rx_xfer.data), .rdata(dd_q)
  );

  lcd_sp_ram #(.AW(CG_AW), .DW(CG_DW)) u_cgram (
    .clk(clk), .we(cg_we), .addr(ac[CG_AW-1:0]),
    .wdata(rx_xfer.data[CG_DW-1:0]), .rdata(cg_q)
  );

  // instruction, counter and data register sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      ac   <= '0;
      tgt  <= TGT_DD;
      inc  <= 1'b1;
      dl   <= 1'b1;
      dr   <= '0;
      bcnt <= '0;
      rl1  <= 1'b0;
      rl2  <= 1'b0;
    end else begin
      rl2 <= rl1;
      rl1 <= 1'b0;
      if (busy_w) bcnt <= bcnt - 1'b1;
      if (rl2) dr <= (tgt == TGT_CG) ? DW'(cg_q) : dd_q;
      if (accept) begin
        bcnt <= CW'(BUSY_CYC);
        unique case (rx_xfer.op)
          OP_WR: ac <= ac_step;
          OP_RD: begin
            ac  <= ac_step;
            rl1 <= 1'b1;
          end
          OP_INSTR: begin
            if (rx_xfer.data[7]) begin
              ac  <= rx_xfer.data[AW-1:0];
              tgt <= TGT_DD;
              rl1 <= 1'b1;
            end else if (rx_xfer.data[6]) begin
              ac[CG_AW-1:0] <= rx_xfer.data[CG_AW-1:0];
              tgt <= TGT_CG;
              rl1 <= 1'b1;
            end else if (rx_xfer.data[5]) begin
              dl <= rx_xfer.data[4];
            end else if (rx_xfer.data[7:2] == 6'b000001) begin
              inc <= rx_xfer.data[1];
            end
          end
          OP_STAT: ;
        endcase
      end
    end
  end

  // registered read-back path
  assign rd_byte = rs ? dr : DW'({busy_w, ac});

  always_ff @(posedge clk) begin
    if (rst) begin
      db_out <= '0;
      db_oe  <= 1'b0;
    end else begin
      db_oe <= en && rw;
      if (!(en && rw))  db_out <= '0;
      else if (dl)      db_out <= rd_byte;
      else if (rx_phase) db_out <= {rd_byte[HW-1:0], {HW{1'b0}}};
      else              db_out <= {rd_byte[DW-1:HW], {HW{1'b0}}};
    end
  end
endmodule

// File: rtl/lcd_host_if_chk.sv
module lcd_host_if_chk #(
  parameter int AW       = 7,
  parameter int DW       = 8,
  parameter int BUSY_CYC = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          done,
  input logic          busy,
  input logic [1:0]    op,
  input logic [DW-1:0] data,
  input logic [AW-1:0] ac,
  input logic [DW-1:0] dr,
  input logic          db_oe,
  input logic          inc
);
  localparam int RW_ = $clog2(BUSY_CYC + 2);

  logic [RW_-1:0] run;

  always_ff @(posedge clk) begin
    if (rst || !busy) run <= '0;
    else if (run != '1) run <= run + 1'b1;
  end

  p_busy_len_r10: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run < RW_'(BUSY_CYC)));

  p_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (done && busy && op != 2'b01) |=> $stable(ac));

  p_stat_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (done && op == 2'b01) |=> $stable(ac));

  p_cg_set_r3: assert property (@(posedge clk) disable iff (rst)
    (done && !busy && op == 2'b00 && data[7:6] == 2'b01)
    |=> ac == {$past(ac[AW-1]), $past(data[AW-2:0])});

  p_dd_set_r4: assert property (@(posedge clk) disable iff (rst)
    (done && !busy && op == 2'b00 && data[7])
    |=> ac == $past(data[AW-1:0]));

  p_wr_step_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !busy && op == 2'b10)
    |=> ac == ($past(inc) ? AW'($past(ac) + 1'b1) : AW'($past(ac) - 1'b1)));

  p_wr_keeps_dr_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !busy && op == 2'b10) |=> $stable(dr));

  p_reset_idle_r12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !db_oe));
endmodule

bind lcd_host_if lcd_host_if_chk #(.AW(AW), .DW(DW), .BUSY_CYC(BUSY_CYC)) u_chk (
  .clk(clk), .rst(rst), .done(rx_done), .busy(busy), .op(rx_xfer.op),
  .data(rx_xfer.data), .ac(ac), .dr(dr), .db_oe(db_oe), .inc(inc)
);

// File: tb/tb_lcd_host_if.sv
module tb_lcd_host_if;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_CYC   = 4;
  localparam int NVEC       = 23;

  // {check, rs, rw, data}; data is the expected value when check = 1
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 8'h85},  // R4 display addr 5
    {1'b0, 1'b1, 1'b0, 8'h41},  // R6 write
    {1'b0, 1'b1, 1'b0, 8'h42},
    {1'b1, 1'b0, 1'b1, 8'h07},  // R5 R6 counter stepped up twice
    {1'b0, 1'b0, 1'b0, 8'h85},
    {1'b1, 1'b1, 1'b1, 8'h41},  // R8 read prefetched byte
    {1'b1, 1'b1, 1'b1, 8'h42},  // R8 refilled from next address
    {1'b1, 1'b0, 1'b1, 8'h07},
    {1'b0, 1'b0, 1'b0, 8'h7F},  // R3 char addr 63, bit6 stays 0
    {1'b0, 1'b1, 1'b0, 8'hFF},
    {1'b1, 1'b0, 1'b1, 8'h40},  // R7 carry into bit6
    {1'b0, 1'b0, 1'b0, 8'h7F},
    {1'b1, 1'b0, 1'b1, 8'h7F},  // R3 bit6 kept at 1
    {1'b1, 1'b1, 1'b1, 8'h1F},  // R6 upper bits of char data dropped
    {1'b1, 1'b0, 1'b1, 8'h00},  // R6 wrap modulo 128
    {1'b0, 1'b0, 1'b0, 8'h04},  // R6 step down
    {1'b0, 1'b0, 1'b0, 8'h90},
    {1'b0, 1'b1, 1'b0, 8'h11},
    {1'b1, 1'b0, 1'b1, 8'h0F},  // R6 decremented
    {1'b0, 1'b0, 1'b0, 8'h90},
    {1'b0, 1'b1, 1'b0, 8'h22},
    {1'b1, 1'b1, 1'b1, 8'h11},  // R9 write left data register alone
    {1'b0, 1'b0, 1'b0, 8'h06}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic       rs  = 1'b0;
  logic       rw  = 1'b0;
  logic [7:0] db_in = '0;
  logic [7:0] db_out;
  logic       db_oe;
  logic       busy;
  int         n_chk  = 0;
  int         n_fail = 0;
  logic [7:0] got;

  lcd_host_if #(.BUSY_CYC(BUSY_CYC)) dut (
    .clk(clk), .rst(rst), .en(en), .rs(rs), .rw(rw), .db_in(db_in),
    .db_out(db_out), .db_oe(db_oe), .busy(busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic s, input logic [7:0] d);
    @(negedge clk);
    rs = s; rw = 1'b0; db_in = d; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic read_strobe(input logic s, output logic [7:0] v);
    @(negedge clk);
    rs = s; rw = 1'b1; en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    v  = db_out;
    en = 1'b0;
  endtask

  task automatic idle();
    repeat (BUSY_CYC + 5) @(negedge clk);
  endtask

  task automatic op8(input logic s, input logic [7:0] d);
    strobe(s, d);
    idle();
  endtask

  task automatic rd8(input logic s, output logic [7:0] v);
    read_strobe(s, v);
    idle();
  endtask

  task automatic op4(input logic s, input logic [7:0] d);
    strobe(s, {d[7:4], 4'hF});
    strobe(s, {d[3:0], 4'hA});
    idle();
  endtask

  task automatic rd4(input logic s, output logic [7:0] v);
    logic [7:0] a, b;
    read_strobe(s, a);
    read_strobe(s, b);
    v = {a[7:4], b[7:4]};
    check("R2 low pins zero", {a[3:0], b[3:0]}, 8'h00);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 busy after reset", {7'd0, busy}, 8'h00);
    check("R12 db_oe after reset", {7'd0, db_oe}, 8'h00);
    rd8(1'b0, got);
    check("R12 counter after reset", got, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][10]) begin
        rd8(VEC[i][9], got);
        check($sformatf("R-table vector %0d", i), got, VEC[i][7:0]);
      end else begin
        op8(VEC[i][9], VEC[i][7:0]);
      end
    end

    // R10: busy seen right after a write; counter 0x0E -> 0x0F
    strobe(1'b1, 8'h33);
    read_strobe(1'b0, got);
    check("R10 busy visible after write", got, 8'h8F);
    idle();
    rd8(1'b0, got);
    check("R10 busy cleared", got, 8'h0F);

    // R10: second back-to-back write dropped
    op8(1'b0, 8'hA0);
    strobe(1'b1, 8'h55);
    strobe(1'b1, 8'h66);
    idle();
    rd8(1'b0, got);
    check("R10 dropped write kept counter", got, 8'h21);
    op8(1'b0, 8'hA0);
    rd8(1'b1, got);
    check("R1 R10 stored byte is first one", got, 8'h55);

    // R2 R11: 4-bit mode
    op8(1'b0, 8'h20);
    op4(1'b0, 8'h83);
    op4(1'b1, 8'hA5);
    op4(1'b0, 8'h83);
    rd4(1'b1, got);
    check("R2 nibble data read", got, 8'hA5);
    rd4(1'b0, got);
    check("R2 nibble status read", got, 8'h04);
    op4(1'b0, 8'h30);
    rd8(1'b0, got);
    check("R11 back to 8-bit", got, 8'h04);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule